// File: doc/BRIEF.md
# Four-Digit Multiplexed Seven-Segment Scan Driver

The block turns four latched BCD digits into the drive signals for a four-digit multiplexed seven-segment display. A slow scan tick, a short pulse from an external oscillator, steps a four-phase digit counter. Each phase selects one digit. The block decodes that digit to segment lines and raises one digit strobe. The scan starts at the most significant digit and works down to the least. While the tick is high every strobe is off, which gives a short dark gap between digits and so avoids ghosting. Each digit is therefore lit for one quarter of the tick rate.

A two-bit display mode selects one of three settings: normal operation with leading zeros suppressed, operation with all zeros shown, or segments dark. A separate display-off input switches all drivers off and releases the BCD port. It also parks the scan at the most significant digit. The counting logic around the block keeps running during display-off. When the display is on, the block puts the selected digit on a BCD output. A parameter sets the output polarity for common-anode or common-cathode displays.

Top module: `seg_scan_drv`

## Requirements
- R1: The scan phase steps D4, D3, D2, D1, then back to D4. It advances by exactly one on each rising edge of `scan_tick` seen at a clock edge, so a tick held high for many cycles advances it only once.
- R2: While `scan_tick` is high, every digit strobe is inactive. While it is low and the display is on, exactly one strobe is active: the one of the current phase. `dig_o[3]` is D4 and `dig_o[0]` is D1.
- R3: `digits_i[15:12]` holds D4, `[11:8]` holds D3, `[7:4]` holds D2 and `[3:0]` holds D1. Segment bit 0 is a and bit 6 is g. The active patterns (g..a) for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F. Codes 10 to 15 light no segment.
- R4: With `disp_ctl` = 2'b00, a zero digit is dark when every more significant digit is also zero. A non-BCD code counts as non-zero. D1 is never suppressed, so 0000 shows a single 0.
- R5: With `disp_ctl` = 2'b01, zeros are never suppressed, and every digit shows its own pattern.
- R6: With `disp_ctl` = 2'b10 or 2'b11, all segments are inactive. Strobes and phase stepping carry on as usual.
- R7: While `disp_off` is high, all segments and strobes are inactive, `bcd_oe_o` is low and `bcd_o` is 0. The phase is forced to D4, and ticks during this time do not advance it.
- R8: While the display is on, `bcd_oe_o` is high and `bcd_o` carries the digit of the current phase. This holds whether or not the tick is high.
- R9: With `COMMON_ANODE` = 1, segment lines are active low and strobes active high. With `COMMON_ANODE` = 0, segment lines are active high and strobes active low.
- R10: After reset the phase is D4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | Scan pulse, synchronous to clk |
| disp_off | input | 1 | Display-off request |
| disp_ctl | input | 2 | Display mode: 00 normal, 01 zeros shown, 10/11 segments dark |
| digits_i | input | 16 | Four latched BCD digits, D4 in the top nibble |
| seg_o | output | 7 | Segment lines a..g, polarity set by COMMON_ANODE |
| dig_o | output | 4 | Digit strobes D4..D1, polarity set by COMMON_ANODE |
| bcd_o | output | 4 | BCD of the digit being scanned |
| bcd_oe_o | output | 1 | BCD output enable |

## Verification
The bench builds two copies of the block that share all inputs. One copy uses the default `COMMON_ANODE` = 1 and the other uses 0, with `NUM_DIGITS` at 4 in both. Each expected active-true pattern is then checked against both polarities in the same cycle, which brings both generate branches of the output stage within reach. The vector table covers leading-zero runs, a zero after a non-zero digit, non-BCD codes and each display mode. Directed tests cover a held tick and display-off in the middle of a scan.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL    = 2'b00,
    MODE_ZEROS_ON  = 2'b01,
    MODE_DARK      = 2'b10,
    MODE_DARK_ALT  = 2'b11
  } disp_mode_e;

  // Active-true segment pattern, bit 0 = a ... bit 6 = g.
  function automatic logic [6:0] bcd_to_seg(input logic [3:0] v);
    logic [6:0] p;
    case (v)
      4'd0: p = 7'h3F;
      4'd1: p = 7'h06;
      4'd2: p = 7'h5B;
      4'd3: p = 7'h4F;
      4'd4: p = 7'h66;
      4'd5: p = 7'h6D;
      4'd6: p = 7'h7D;
      4'd7: p = 7'h07;
      4'd8: p = 7'h7F;
      4'd9: p = 7'h6F;
      default: p = 7'h00;
    endcase
    return p;
  endfunction

  function automatic logic mode_lights(input disp_mode_e m);
    return (m == MODE_NORMAL) || (m == MODE_ZEROS_ON);
  endfunction

endpackage

// File: rtl/scan_phase_ctr.sv
module scan_phase_ctr #(
  parameter int NUM_DIGITS = 4,
  localparam int PH_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_tick,
  input  logic            hold,
  output logic [PH_W-1:0] phase,
  output logic            tick_rise
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_DIGITS - 1);

  logic tick_q;

  assign tick_rise = scan_tick & ~tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      phase  <= '0;
    end else begin
      tick_q <= scan_tick;
      if (hold) begin
        phase <= '0;
      end else if (tick_rise) begin
        phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
      end
    end
  end

endmodule

// File: rtl/digit_pick_blank.sv
module digit_pick_blank #(
  parameter int NUM_DIGITS = 4,
  localparam int PH_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int DW   = 4 * NUM_DIGITS
) (
  input  logic [DW-1:0]         digits,
  input  logic [PH_W-1:0]       phase,
  input  logic                  lzb_en,
  output logic [PH_W-1:0]       sel_idx,
  output logic [3:0]            cur_digit,
  output logic                  cur_blank,
  output logic [NUM_DIGITS-1:0] lead_zero
);

  logic [NUM_DIGITS-1:0] is_zero;

  // Phase 0 selects the most significant digit.
  assign sel_idx = PH_W'(NUM_DIGITS - 1) - phase;

  genvar k;
  generate
    for (k = 0; k < NUM_DIGITS; k++) begin : g_zero
      assign is_zero[k] = (digits[4*k +: 4] == 4'd0);
      if (k == 0) begin : g_lsd
        assign lead_zero[k] = 1'b0;
      end else if (k == NUM_DIGITS - 1) begin : g_msd
        assign lead_zero[k] = is_zero[k];
      end else begin : g_mid
        assign lead_zero[k] = is_zero[k] & lead_zero[k+1];
      end
    end
  endgenerate

  always_comb begin
    cur_digit = digits[4*sel_idx +: 4];
    cur_blank = lzb_en & lead_zero[sel_idx];
  end

endmodule

// File: rtl/seg_out_drive.sv
module seg_out_drive #(
  parameter int NUM_DIGITS   = 4,
  parameter bit COMMON_ANODE = 1'b1
) (
  input  logic [6:0]            seg_act,
  input  logic [NUM_DIGITS-1:0] dig_act,
  output logic [6:0]            seg_o,
  output logic [NUM_DIGITS-1:0] dig_o
);

  generate
    if (COMMON_ANODE) begin : g_anode
      assign seg_o = ~seg_act;
      assign dig_o = dig_act;
    end else begin : g_cathode
      assign seg_o = seg_act;
      assign dig_o = ~dig_act;
    end
  endgenerate

endmodule

// File: rtl/seg_scan_drv.sv
module seg_scan_drv
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS   = 4,
  parameter bit COMMON_ANODE = 1'b1,
  localparam int PH_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int DW   = 4 * NUM_DIGITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_tick,
  input  logic                  disp_off,
  input  logic [1:0]            disp_ctl,
  input  logic [DW-1:0]         digits_i,
  output logic [6:0]            seg_o,
  output logic [NUM_DIGITS-1:0] dig_o,
  output logic [3:0]            bcd_o,
  output logic                  bcd_oe_o
);

  disp_mode_e            mode;
  logic [PH_W-1:0]       phase;
  logic                  tick_rise;
  logic [PH_W-1:0]       sel_idx;
  logic [3:0]            cur_digit;
  logic                  cur_blank;
  logic [NUM_DIGITS-1:0] lead_zero;
  logic                  strobe_en;
  logic                  seg_en;
  logic [6:0]            seg_act;
  logic [NUM_DIGITS-1:0] dig_act;

  assign mode = disp_mode_e'(disp_ctl);

  scan_phase_ctr #(.NUM_DIGITS(NUM_DIGITS)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .hold      (disp_off),
    .phase     (phase),
    .tick_rise (tick_rise)
  );

  digit_pick_blank #(.NUM_DIGITS(NUM_DIGITS)) u_pick (
    .digits    (digits_i),
    .phase     (phase),
    .lzb_en    (mode == MODE_NORMAL),
    .sel_idx   (sel_idx),
    .cur_digit (cur_digit),
    .cur_blank (cur_blank),
    .lead_zero (lead_zero)
  );

  assign strobe_en = ~disp_off & ~scan_tick;
  assign seg_en    = ~disp_off & mode_lights(mode) & ~cur_blank;

  always_comb begin
    seg_act = seg_en ? bcd_to_seg(cur_digit) : 7'h00;
    dig_act = strobe_en ? (NUM_DIGITS'(1) << sel_idx) : '0;
  end

  seg_out_drive #(.NUM_DIGITS(NUM_DIGITS), .COMMON_ANODE(COMMON_ANODE)) u_drive (
    .seg_act (seg_act),
    .dig_act (dig_act),
    .seg_o   (seg_o),
    .dig_o   (dig_o)
  );

  assign bcd_oe_o = ~disp_off;
  assign bcd_o    = disp_off ? 4'd0 : cur_digit;

endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
  parameter int NUM_DIGITS   = 4,
  parameter bit COMMON_ANODE = 1'b1,
  localparam int PH_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int DW   = 4 * NUM_DIGITS
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scan_tick,
  input logic                  disp_off,
  input logic [1:0]            disp_ctl,
  input logic [DW-1:0]         digits_i,
  input logic [6:0]            seg_o,
  input logic [NUM_DIGITS-1:0] dig_o,
  input logic [3:0]            bcd_o,
  input logic                  bcd_oe_o,
  input logic [PH_W-1:0]       phase,
  input logic                  tick_rise
);

  localparam logic [6:0]            SEG_IDLE = COMMON_ANODE ? 7'h7F : 7'h00;
  localparam logic [NUM_DIGITS-1:0] DIG_IDLE = COMMON_ANODE ? '0 : '1;
  localparam logic [PH_W-1:0]       LAST_PH  = PH_W'(NUM_DIGITS - 1);

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_rise && !disp_off) |=>
      (phase == (($past(phase) == LAST_PH) ? '0 : $past(phase) + 1'b1)));

  a_r1_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_rise && !disp_off) |=> $stable(phase));

  a_r2_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
    scan_tick |-> (dig_o == DIG_IDLE));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_tick && !disp_off) |-> $onehot(dig_o ^ DIG_IDLE));

  a_r4_lsd_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_off && disp_ctl == 2'b00 && phase == LAST_PH && digits_i[3:0] == 4'd0)
      |-> (seg_o == (SEG_IDLE ^ 7'h3F)));

  a_r6_dark: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ctl[1] |-> (seg_o == SEG_IDLE));

  a_r7_parked: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |=> (phase == '0));

  a_r7_released: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> (!bcd_oe_o && bcd_o == 4'd0 && seg_o == SEG_IDLE && dig_o == DIG_IDLE));

endmodule

bind seg_scan_drv seg_scan_chk #(
  .NUM_DIGITS   (NUM_DIGITS),
  .COMMON_ANODE (COMMON_ANODE)
) u_seg_scan_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scan_tick (scan_tick),
  .disp_off  (disp_off),
  .disp_ctl  (disp_ctl),
  .digits_i  (digits_i),
  .seg_o     (seg_o),
  .dig_o     (dig_o),
  .bcd_o     (bcd_o),
  .bcd_oe_o  (bcd_oe_o),
  .phase     (phase),
  .tick_rise (tick_rise)
);

// File: tb/test_seg_scan_drv.sv
module test_seg_scan_drv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_tick = 1'b0;
  logic        disp_off = 1'b0;
  logic [1:0]  disp_ctl = 2'b00;
  logic [15:0] digits = 16'h0000;

  logic [6:0] seg_a, seg_c;
  logic [3:0] dig_a, dig_c, bcd_a, bcd_c;
  logic       oe_a, oe_c;

  int n_checks = 0;
  int n_fail   = 0;
  int bph      = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  seg_scan_drv #(.NUM_DIGITS(4), .COMMON_ANODE(1'b1)) i_seg_scan_drv (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .disp_off(disp_off),
    .disp_ctl(disp_ctl), .digits_i(digits), .seg_o(seg_a), .dig_o(dig_a),
    .bcd_o(bcd_a), .bcd_oe_o(oe_a));

  seg_scan_drv #(.NUM_DIGITS(4), .COMMON_ANODE(1'b0)) i_seg_scan_drv_cc (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .disp_off(disp_off),
    .disp_ctl(disp_ctl), .digits_i(digits), .seg_o(seg_c), .dig_o(dig_c),
    .bcd_o(bcd_c), .bcd_oe_o(oe_c));

  // {digits D4..D1, mode, seg D4, seg D3, seg D2, seg D1}, active-true
  localparam logic [45:0] VEC [8] = '{
    {16'h1234, 2'b00, 7'h06, 7'h5B, 7'h4F, 7'h66},
    {16'h0045, 2'b00, 7'h00, 7'h00, 7'h66, 7'h6D},
    {16'h0000, 2'b00, 7'h00, 7'h00, 7'h00, 7'h3F},
    {16'h0000, 2'b01, 7'h3F, 7'h3F, 7'h3F, 7'h3F},
    {16'h0907, 2'b00, 7'h00, 7'h6F, 7'h3F, 7'h07},
    {16'h0A05, 2'b00, 7'h00, 7'h00, 7'h3F, 7'h6D},
    {16'h5678, 2'b10, 7'h00, 7'h00, 7'h00, 7'h00},
    {16'h8090, 2'b01, 7'h7F, 7'h3F, 7'h6F, 7'h3F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare both polarities against one active-true expectation (R9).
  task automatic check_out(input string req, input logic [6:0] s, input logic [3:0] d,
                           input logic oe, input logic [3:0] b);
    chk({req, " R9 anode"},   {seg_a, dig_a}, {~s, d});
    chk({req, " R9 cathode"}, {seg_c, dig_c}, {s, ~d});
    chk({req, " R8 bcd"},     {oe_a, bcd_a, oe_c, bcd_c}, {oe, b, oe, b});
  endtask

  task automatic tick_pulse();
    @(negedge clk) scan_tick = 1'b1;
    @(posedge clk); #1;
    bph = disp_off ? 0 : (bph + 1) % 4;
    chk("R2 gap", {dig_a, dig_c}, {4'h0, 4'hF});
    @(negedge clk) scan_tick = 1'b0;
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] onehot_of(input int p);
    return 4'b1000 >> p;
  endfunction

  function automatic logic [3:0] nib_of(input logic [15:0] v, input int p);
    return v[(3 - p) * 4 +: 4];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R10 reset at D4; D4 zero suppressed (R4)
    check_out("R10 reset", 7'h00, 4'b1000, 1'b1, 4'h0);

    // Table walk: R3 R4 R5 R6 R8
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      digits   = VEC[e][45:30];
      disp_ctl = VEC[e][29:28];
      @(posedge clk); #1;
      for (int i = 0; i < 4; i++) begin
        check_out("R3 R4 R5 R6 table", VEC[e][(3 - bph) * 7 +: 7],
                  onehot_of(bph), 1'b1, nib_of(digits, bph));
        tick_pulse();
      end
    end

    // R1: a tick held high advances the phase once
    @(negedge clk) begin digits = 16'h1234; disp_ctl = 2'b01; scan_tick = 1'b1; end
    repeat (6) @(posedge clk);
    @(negedge clk) scan_tick = 1'b0;
    @(posedge clk); #1;
    bph = (bph + 1) % 4;
    chk("R1 held tick", dig_a, onehot_of(bph));

    // R1: full order across four ticks
    for (int i = 0; i < 4; i++) begin
      tick_pulse();
      chk("R1 order", dig_a, onehot_of(bph));
    end

    // R7: display off in mid-scan, ticks ignored, release at D4
    while (bph != 2) tick_pulse();
    @(negedge clk) disp_off = 1'b1;
    @(posedge clk); #1;
    bph = 0;
    check_out("R7 off", 7'h00, 4'b0000, 1'b0, 4'h0);
    tick_pulse();
    tick_pulse();
    check_out("R7 off ticks", 7'h00, 4'b0000, 1'b0, 4'h0);
    @(negedge clk) disp_off = 1'b0;
    @(posedge clk); #1;
    check_out("R7 parked D4", 7'h06, 4'b1000, 1'b1, 4'h1);

    // R8: BCD held during the tick gap
    @(negedge clk) scan_tick = 1'b1;
    @(posedge clk); #1;
    chk("R8 bcd in gap", bcd_a, 4'h2);
    @(negedge clk) scan_tick = 1'b0;
    @(posedge clk); #1;
    bph = 1;

    // R6 with mode 11: dark segments, strobes carry on
    @(negedge clk) disp_ctl = 2'b11;
    @(posedge clk); #1;
    check_out("R6 mode 11", 7'h00, onehot_of(bph), 1'b1, 4'h2);

    finish_run();
  end

endmodule